// File: doc/BRIEF.md
# Ethernet Frame Check Residue Checker

This block checks received Ethernet frames on a path that carries eight bytes per clock. The frame's first word is marked by a start strobe. The CRC-32 register is preset to all ones on that word. The register is then updated over every byte of the frame: addresses, length/type, payload, pad, and the received check field itself. The block never stops early to compute a separate value and compare it with the check field.

After the last byte, the register is compared without complementing it against the single constant that every error-free frame leaves behind. The verdict comes out as a one-clock pulse on either the good output or the bad output.

The last word of a frame may carry from one to eight valid bytes. A small count input selects how many lanes of that word are included. The block sits behind a receive datapath clocked at up to 200 MHz. Removing the check field and discarding bad frames are left to the logic downstream.

Top module: `eth_fcs_chk`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `frame_good` and `frame_bad` are both low, and no frame is open.
- R2: The register uses generator polynomial 0x04C11DB7 in a most-significant-bit-first shift register. It is preset to all ones by any accepted word with `in_sof` high. Bytes are taken lane 0 first (lane k is `in_data[8k+7:8k]`), and each byte is taken least significant bit first.
- R3: The register runs over every byte of the frame, including the four check bytes. The frame is good exactly when the uncomplemented register after the last byte equals 0xC704DD7B.
- R4: On the word that carries `in_eof`, only lanes 0 to `in_last_m1` are used (that is, `in_last_m1`+1 bytes, with value 7 meaning all eight). The contents of the higher lanes have no effect.
- R5: The verdict appears in the clock cycle after the accepted end-of-frame word, as a pulse exactly one cycle wide on one of `frame_good` or `frame_bad`, never both. Both outputs are low in every other cycle.
- R6: A frame whose check field matches its contents, but with any single bit inverted anywhere in it, is reported on `frame_bad`.
- R7: A word with `in_sof` high restarts the check from the preset, even if an earlier frame never received its end word.
- R8: Cycles with `in_valid` low change nothing, whatever the other inputs carry, so idle gaps inside a frame do not alter the verdict.
- R9: A valid word with `in_sof` low that arrives while no frame is open is ignored, and an `in_eof` on such a word produces no pulse.
- R10: A word carrying both `in_sof` and `in_eof` is checked as a complete one-word frame.
- R11: `in_last_m1` has no effect on words without `in_eof`; all eight lanes are used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word on the data inputs is valid this cycle |
| in_sof | input | 1 | Word is the first of a frame |
| in_eof | input | 1 | Word is the last of a frame |
| in_data | input | 64 | Eight byte lanes, lane 0 first on the wire |
| in_last_m1 | input | 3 | Index of the last valid lane on the end word |
| frame_good | output | 1 | One-cycle pulse: residue matched |
| frame_bad | output | 1 | One-cycle pulse: residue mismatched |

## Verification
The assertions take for granted that `in_sof`, `in_eof` and `in_last_m1` matter only on words with `in_valid` high. They also take for granted that a frame's end word, once accepted, closes that frame.

The stimulus deliberately breaks the friendlier conventions. It drives random levels on the framing strobes and on the byte count during idle cycles and on middle words. It fills the unused lanes of end words with random bytes. It abandons frames without an end word and sends stray end words while no frame is open.

Good frames are built with a bench-side check field. Each good frame is then replayed with one random bit inverted.

// File: rtl/fcs_chk_pkg.sv
package fcs_chk_pkg;

    localparam int              CRC_W       = 32;
    localparam int              SYM_W       = 8;
    localparam logic [CRC_W-1:0] CRC_POLY    = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] CRC_PRESET  = '1;
    localparam logic [CRC_W-1:0] CRC_RESIDUE = 32'hC704_DD7B;

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic             active;
        logic             good;
        logic             bad;
    } chk_state_t;

endpackage

// File: rtl/fcs_byte_lane.sv
module fcs_byte_lane #(
    parameter int                CRC_W = 32,
    parameter int                SYM_W = 8,
    parameter logic [CRC_W-1:0]  POLY  = 32'h04C1_1DB7
) (
    input  logic [CRC_W-1:0] crc_i,
    input  logic [SYM_W-1:0] sym_i,
    output logic [CRC_W-1:0] crc_o
);

    // Serial division unrolled over one symbol, least significant bit first.
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_i;
        for (int b = 0; b < SYM_W; b++) begin
            fb = c[CRC_W-1] ^ sym_i[b];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) begin
                c = c ^ POLY;
            end
        end
        crc_o = c;
    end

endmodule

// File: rtl/fcs_word_crc.sv
module fcs_word_crc #(
    parameter int               LANES = 8,
    parameter int               CRC_W = 32,
    parameter int               SYM_W = 8,
    parameter logic [CRC_W-1:0] POLY  = 32'h04C1_1DB7,
    localparam int              CNT_W = $clog2(LANES + 1)
) (
    input  logic [CRC_W-1:0]       crc_i,
    input  logic [LANES*SYM_W-1:0] data_i,
    input  logic [CNT_W-1:0]       nbytes_i,
    output logic [CRC_W-1:0]       crc_o
);

    logic [CRC_W-1:0] tap [LANES+1];

    assign tap[0] = crc_i;

    // Chain of lane updates; tap[k] holds the register after k lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fcs_byte_lane #(
            .CRC_W (CRC_W),
            .SYM_W (SYM_W),
            .POLY  (POLY)
        ) lane_i (
            .crc_i (tap[g]),
            .sym_i (data_i[g*SYM_W +: SYM_W]),
            .crc_o (tap[g+1])
        );
    end

    // Pick the tap after the requested number of lanes; full word otherwise.
    always_comb begin
        crc_o = tap[LANES];
        for (int k = 1; k <= LANES; k++) begin
            if (nbytes_i == CNT_W'(k)) begin
                crc_o = tap[k];
            end
        end
    end

endmodule

// File: rtl/eth_fcs_chk.sv
module eth_fcs_chk #(
    parameter int LANES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic                       in_sof,
    input  logic                       in_eof,
    input  logic [LANES*8-1:0]         in_data,
    input  logic [$clog2(LANES)-1:0]   in_last_m1,
    output logic                       frame_good,
    output logic                       frame_bad
);
    import fcs_chk_pkg::*;

    localparam int CNT_W  = $clog2(LANES + 1);

    chk_state_t       st_d, st_q;
    logic             accept;
    logic [CRC_W-1:0] seed;
    logic [CRC_W-1:0] upd;
    logic [CNT_W-1:0] nbytes;

    // A word counts when it opens a frame or continues an open one.
    assign accept = in_valid && (in_sof || st_q.active);
    assign seed   = in_sof ? CRC_PRESET : st_q.crc;
    assign nbytes = in_eof ? (CNT_W'(in_last_m1) + CNT_W'(1)) : CNT_W'(LANES);

    fcs_word_crc #(
        .LANES (LANES),
        .CRC_W (CRC_W),
        .SYM_W (SYM_W),
        .POLY  (CRC_POLY)
    ) word_i (
        .crc_i    (seed),
        .data_i   (in_data),
        .nbytes_i (nbytes),
        .crc_o    (upd)
    );

    always_comb begin
        st_d      = st_q;
        st_d.good = 1'b0;
        st_d.bad  = 1'b0;
        if (accept) begin
            st_d.crc    = upd;
            st_d.active = !in_eof;
            if (in_eof) begin
                st_d.good = (upd == CRC_RESIDUE);
                st_d.bad  = (upd != CRC_RESIDUE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.crc    <= CRC_PRESET;
            st_q.active <= 1'b0;
            st_q.good   <= 1'b0;
            st_q.bad    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_good = st_q.good;
    assign frame_bad  = st_q.bad;

    // R5
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_good && frame_bad));

    // R5
    eof_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eof && (in_sof || st_q.active)) |=> (frame_good || frame_bad));

    // R9
    verdict_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_good || frame_bad) |->
            $past(in_valid && in_eof && (in_sof || st_q.active)));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(st_q.crc) && $stable(st_q.active)));

    // R7
    sof_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && !in_eof) |=> st_q.active);

endmodule

// File: tb/eth_fcs_chk_tb_top.sv
module eth_fcs_chk_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_BYTES  = 72;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_sof;
    logic        in_eof;
    logic [63:0] in_data;
    logic [2:0]  in_last_m1;
    logic        frame_good;
    logic        frame_bad;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [7:0]  fr [MAX_BYTES];
    int          fr_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_fcs_chk dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .in_data    (in_data),
        .in_last_m1 (in_last_m1),
        .frame_good (frame_good),
        .frame_bad  (frame_bad)
    );

    // Reflected reference CRC over fr[0..n-1], preset ones, returned uncomplemented.
    function automatic logic [31:0] ref_crc(int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c = c ^ {24'h0, fr[i]};
            for (int b = 0; b < 8; b++) begin
                c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
            end
        end
        return c;
    endfunction

    task automatic build_frame(input int plen);
        logic [31:0] fcs;
        for (int i = 0; i < plen; i++) fr[i] = 8'($urandom);
        fcs = ~ref_crc(plen);
        for (int i = 0; i < 4; i++) fr[plen+i] = fcs[8*i +: 8];
        fr_len = plen + 4;
    endtask

    task automatic check(input bit ok, input string req,
                         input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: {good,bad} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic drive_idle();
        in_valid   = 1'b0;
        in_sof     = 1'($urandom);
        in_eof     = 1'($urandom);
        in_data    = {$urandom, $urandom};
        in_last_m1 = 3'($urandom);
    endtask

    // Sends fr[0..fr_len-1]; checks the verdict one cycle after the end word
    // and that it lasts exactly one cycle.
    task automatic send_frame(input bit gaps, input bit exp_good, input string req);
        int nw = (fr_len + 7) / 8;
        for (int w = 0; w < nw; w++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                @(negedge clk);
                drive_idle();   // R8
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (w == 0);
            in_eof   = (w == nw - 1);
            for (int l = 0; l < 8; l++) begin
                in_data[8*l +: 8] = (w*8 + l < fr_len) ? fr[w*8 + l] : 8'($urandom); // R4
            end
            in_last_m1 = (w == nw - 1) ? 3'((fr_len - 1) % 8) : 3'($urandom);    // R11
        end
        @(negedge clk);
        check({frame_good, frame_bad} == {exp_good, !exp_good}, req,
              {frame_good, frame_bad}, {exp_good, !exp_good});
        drive_idle();
        @(negedge clk);
        check({frame_good, frame_bad} == 2'b00, "R5", {frame_good, frame_bad}, 2'b00);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240419));
        rst_n = 1'b0;
        drive_idle();
        repeat (3) @(negedge clk);
        // R1: outputs low in reset
        check({frame_good, frame_bad} == 2'b00, "R1", {frame_good, frame_bad}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check({frame_good, frame_bad} == 2'b00, "R1", {frame_good, frame_bad}, 2'b00);

        // R10: single-word frames, 8 and 5 bytes
        build_frame(4);  send_frame(1'b0, 1'b1, "R10");
        build_frame(1);  send_frame(1'b0, 1'b1, "R10");
        // R4: last word with all lanes, and with only lane 0
        build_frame(12); send_frame(1'b0, 1'b1, "R4");
        build_frame(5);  send_frame(1'b0, 1'b1, "R4");
        // R2/R3: minimum-size frame
        build_frame(60); send_frame(1'b0, 1'b1, "R3");

        // R7: abandoned frame, then restart
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b0;
        in_data = {$urandom, $urandom}; in_last_m1 = 3'($urandom);
        @(negedge clk);
        in_sof = 1'b0; in_data = {$urandom, $urandom};
        build_frame(20); send_frame(1'b0, 1'b1, "R7");

        // R9: stray end word while no frame is open
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b1;
        in_data = {$urandom, $urandom}; in_last_m1 = 3'($urandom);
        @(negedge clk);
        check({frame_good, frame_bad} == 2'b00, "R9", {frame_good, frame_bad}, 2'b00);
        drive_idle();
        build_frame(9); send_frame(1'b1, 1'b1, "R9");

        // R2/R3/R6/R8: random frames, good then with a single inverted bit
        for (int it = 0; it < 200; it++) begin
            int pos;
            build_frame(1 + int'($urandom % 64));
            send_frame(1'b1, 1'b1, "R3");
            pos = int'($urandom % (fr_len * 8));
            fr[pos/8][pos%8] = ~fr[pos/8][pos%8];
            send_frame(1'b1, 1'b0, "R6");
        end

        finish_run();
    end

endmodule